// File: doc/BRIEF.md
# SD Card SPI-Mode Byte Sequencer

This block sits on the card side of an SD memory card that runs in SPI mode. Every SPI byte exchange hands it one byte from the host and takes back one byte for the host. The shift register around it flags each finished exchange with `xfer_valid`. The sequencer decodes the command frame and passes the command index and the 32-bit argument to a card back-end in a single request strobe. The back-end answers in the same cycle. The sequencer then returns the response bytes, with the gap bytes the SPI timing requires placed around them.

When the back-end reports that a read block follows, the block frames that block. It sends one gap byte, then the start token, then the data bytes fetched from the back-end one per exchange, then a 16-bit CRC computed over those bytes. While a block is streaming, the host can send the first byte of a stop-transmission command. That byte aborts the read at once, and the sequencer inserts one extra delay byte before the stop command's response.

Top module: `sdspi_card_seq`

## Requirements
- R1: When the block is idle and receives the byte 0xFF, it treats it as a null command. It returns 0xFF, raises no request and stays idle.
- R2: Any other byte received while idle starts a command, and the command index is that byte's bits [5:0]. The next 4 exchanges each return 0xFF. On the 4th of them `req_valid` pulses for that one exchange, carrying the index and the argument, with the first argument byte in bits [31:24].
- R3: The exchange right after the 4th argument byte returns one 0xFF gap byte, and no response byte goes out in it.
- R4: The response bytes then follow, one per exchange. Byte k is taken from `rsp_bytes[8k+7:8k]`, starting at k = 0. After the last one the block returns to idle if `rsp_data` was 0 at the request.
- R5: The response length comes from `rsp_len` at the request. A value of 0 counts as 1, and a value above 5 counts as 5.
- R6: If `rsp_data` was 1, the response is followed by one 0xFF gap byte and then the token 0xFE. Each data byte after that is `rd_byte`, and `rd_strobe` pulses once per data exchange.
- R7: The data byte that comes with `rd_last` = 1 is the last one. The next two exchanges return the CRC, high byte first, and the block is idle after them.
- R8: The CRC uses polynomial 0x1021. Bits are fed most significant first, with no reflection and no final inversion. It starts from 0x0000 at every token, so the bytes "123456789" give 0x31C3.
- R9: During data streaming, a received 0x4C aborts the read. That exchange returns 0xFF, fetches no byte and starts a command with index 12, and no CRC is sent. After that command's gap byte, one extra 0xFF comes before its first response byte.
- R10: After reset the block is idle, `card_byte` reads 0xFF, and no strobe is raised.
- R11: In a cycle without `xfer_valid`, the block raises no strobe, and neither `card_byte` nor the sequence position changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | One byte exchange completes in this cycle |
| host_byte | input | 8 | Byte received from the host |
| card_byte | output | 8 | Byte returned for the latest exchange |
| req_valid | output | 1 | Command request strobe to the back-end |
| req_cmd | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| rsp_len | input | 3 | Response length in bytes, sampled with the request |
| rsp_bytes | input | 40 | Response bytes; byte k at [8k+7:8k] |
| rsp_data | input | 1 | A read block follows the response |
| rd_strobe | output | 1 | Fetches one data byte from the back-end |
| rd_byte | input | 8 | Data byte offered by the back-end |
| rd_last | input | 1 | The offered byte is the final one of the block |

## Verification
The case that is hardest to reach from the ports is a stop byte arriving partway through a block. The CRC must then be dropped, and the delay byte must come after the stop command's own gap byte. The bench gets there by opening a read and consuming a few data bytes, then sending 0x4C in place of a dummy byte. It then checks every exchange until the stop response ends. Separate sweeps cover every value of the 3-bit length field with and without a data block, and a fixed block with a known CRC pins the polynomial and bit order.

// File: rtl/sdspi_seq_pkg.sv
package sdspi_seq_pkg;
  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] TOKEN_BYTE = 8'hFE;
  localparam logic [7:0] STOP_BYTE  = 8'h4C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARG,
    ST_NCR,
    ST_RESP,
    ST_NAC,
    ST_TOKEN,
    ST_DATA,
    ST_CRC
  } seq_state_e;
endpackage

// File: rtl/sdspi_crc16.sv
module sdspi_crc16 #(
  parameter int          CW   = 16,
  parameter logic [15:0] POLY = 16'h1021,
  parameter int          DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [DW-1:0] din,
  output logic [CW-1:0] crc
);
  logic [CW-1:0] crc_q;
  logic [CW-1:0] stage [DW+1];

  assign stage[0] = crc_q;

  // One shift-and-reduce step per data bit, most significant bit first.
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic fb;
    assign fb         = stage[i][CW-1] ^ din[DW-1-i];
    assign stage[i+1] = {stage[i][CW-2:0], 1'b0} ^ (fb ? POLY[CW-1:0] : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (clr) begin
      crc_q <= '0;
    end else if (upd) begin
      crc_q <= stage[DW];
    end
  end

  assign crc = crc_q;

  a_r8_clear_start: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == '0));
endmodule

// File: rtl/sdspi_cmd_capture.sv
module sdspi_cmd_capture #(
  parameter int ARG_BYTES = 4,
  localparam int AW = 8 * ARG_BYTES,
  localparam int NW = $clog2(ARG_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          shift,
  input  logic [7:0]    din,
  output logic [5:0]    cmd_idx,
  output logic [AW-1:0] arg_word,
  output logic          arg_last
);
  logic [5:0]    cmd_q;
  logic [AW-1:0] arg_q;
  logic [NW-1:0] cnt_q;

  // The current byte enters at the bottom, so the first byte ends up at the top.
  assign arg_word = {arg_q[AW-9:0], din};
  assign arg_last = shift && (cnt_q == NW'(ARG_BYTES - 1));
  assign cmd_idx  = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      arg_q <= '0;
      cnt_q <= '0;
    end else if (start) begin
      cmd_q <= din[5:0];
      cnt_q <= '0;
    end else if (shift) begin
      arg_q <= arg_word;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r2_arg_count: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= NW'(ARG_BYTES));
  a_r2_last_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (arg_last && !start) |=> (cnt_q == NW'(ARG_BYTES)));
endmodule

// File: rtl/sdspi_rsp_buf.sv
module sdspi_rsp_buf #(
  parameter int MAXB = 5,
  localparam int LW = $clog2(MAXB + 1),
  localparam int BW = 8 * MAXB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [LW-1:0] len_in,
  input  logic [BW-1:0] bytes_in,
  input  logic          data_in,
  input  logic          advance,
  output logic [7:0]    cur_byte,
  output logic          is_last,
  output logic          data_follows
);
  logic [BW-1:0] bytes_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] len_eff;
  logic [LW-1:0] idx_q;
  logic          data_q;

  always_comb begin
    if (len_in == '0) begin
      len_eff = LW'(1);
    end else if (len_in > LW'(MAXB)) begin
      len_eff = LW'(MAXB);
    end else begin
      len_eff = len_in;
    end
  end

  assign cur_byte     = bytes_q[idx_q*8 +: 8];
  assign is_last      = (idx_q == len_q - LW'(1));
  assign data_follows = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      len_q   <= LW'(1);
      idx_q   <= '0;
      data_q  <= 1'b0;
    end else if (capture) begin
      bytes_q <= bytes_in;
      len_q   <= len_eff;
      idx_q   <= '0;
      data_q  <= data_in;
    end else if (advance && !is_last) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  a_r5_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= LW'(1)) && (len_q <= LW'(MAXB)));
  a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < len_q);
endmodule

// File: rtl/sdspi_card_seq.sv
module sdspi_card_seq #(
  parameter int  ARG_BYTES = 4,
  parameter int  RSP_MAX   = 5,
  localparam int LEN_W     = $clog2(RSP_MAX + 1),
  localparam int AW        = 8 * ARG_BYTES,
  localparam int RW        = 8 * RSP_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_valid,
  input  logic [7:0]       host_byte,
  output logic [7:0]       card_byte,
  output logic             req_valid,
  output logic [5:0]       req_cmd,
  output logic [AW-1:0]    req_arg,
  input  logic [LEN_W-1:0] rsp_len,
  input  logic [RW-1:0]    rsp_bytes,
  input  logic             rsp_data,
  output logic             rd_strobe,
  input  logic [7:0]       rd_byte,
  input  logic             rd_last
);
  import sdspi_seq_pkg::*;

  seq_state_e  state_q, state_d;
  logic [7:0]  card_q, reply_d;
  logic        stop_q, stop_set, stop_clr;
  logic        crc_lo_q, crc_lo_d;

  logic        cap_start, cap_shift, cap_last;
  logic        rb_advance, rb_last, rb_data;
  logic [7:0]  rb_byte;
  logic        crc_clr, crc_upd;
  logic [15:0] crc_val;
  logic        stop_hit;

  sdspi_cmd_capture #(.ARG_BYTES(ARG_BYTES)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cap_start),
    .shift    (cap_shift),
    .din      (host_byte),
    .cmd_idx  (req_cmd),
    .arg_word (req_arg),
    .arg_last (cap_last)
  );

  sdspi_rsp_buf #(.MAXB(RSP_MAX)) u_rsp (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (req_valid),
    .len_in       (rsp_len),
    .bytes_in     (rsp_bytes),
    .data_in      (rsp_data),
    .advance      (rb_advance),
    .cur_byte     (rb_byte),
    .is_last      (rb_last),
    .data_follows (rb_data)
  );

  sdspi_crc16 #(.CW(16), .POLY(16'h1021), .DW(8)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .upd   (crc_upd),
    .din   (rd_byte),
    .crc   (crc_val)
  );

  assign stop_hit = xfer_valid && (state_q == ST_DATA) && (host_byte == STOP_BYTE);

  always_comb begin
    state_d    = state_q;
    reply_d    = FILL_BYTE;
    cap_start  = 1'b0;
    cap_shift  = 1'b0;
    req_valid  = 1'b0;
    rb_advance = 1'b0;
    rd_strobe  = 1'b0;
    crc_clr    = 1'b0;
    crc_upd    = 1'b0;
    stop_set   = 1'b0;
    stop_clr   = 1'b0;
    crc_lo_d   = crc_lo_q;
    if (stop_hit) begin
      // The stop byte is itself the command byte of the next frame.
      cap_start = 1'b1;
      stop_set  = 1'b1;
      state_d   = ST_ARG;
    end else if (xfer_valid) begin
      unique case (state_q)
        ST_IDLE: begin
          if (host_byte != FILL_BYTE) begin
            cap_start = 1'b1;
            state_d   = ST_ARG;
          end
        end
        ST_ARG: begin
          cap_shift = 1'b1;
          if (cap_last) begin
            req_valid = 1'b1;
            state_d   = ST_NCR;
          end
        end
        ST_NCR: begin
          state_d = ST_RESP;
        end
        ST_RESP: begin
          if (stop_q) begin
            stop_clr = 1'b1;
          end else begin
            reply_d    = rb_byte;
            rb_advance = 1'b1;
            if (rb_last) begin
              state_d = rb_data ? ST_NAC : ST_IDLE;
            end
          end
        end
        ST_NAC: begin
          state_d = ST_TOKEN;
        end
        ST_TOKEN: begin
          reply_d = TOKEN_BYTE;
          crc_clr = 1'b1;
          state_d = ST_DATA;
        end
        ST_DATA: begin
          reply_d   = rd_byte;
          rd_strobe = 1'b1;
          crc_upd   = 1'b1;
          if (rd_last) begin
            crc_lo_d = 1'b0;
            state_d  = ST_CRC;
          end
        end
        ST_CRC: begin
          reply_d  = crc_lo_q ? crc_val[7:0] : crc_val[15:8];
          crc_lo_d = 1'b1;
          if (crc_lo_q) begin
            state_d = ST_IDLE;
          end
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      card_q   <= FILL_BYTE;
      stop_q   <= 1'b0;
      crc_lo_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      crc_lo_q <= crc_lo_d;
      if (xfer_valid) begin
        card_q <= reply_d;
      end
      if (stop_set) begin
        stop_q <= 1'b1;
      end else if (stop_clr) begin
        stop_q <= 1'b0;
      end
    end
  end

  assign card_byte = card_q;

  a_r2_req_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (xfer_valid && state_q == ST_ARG));
  a_r3_gap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (state_q == ST_NCR && card_byte == FILL_BYTE));
  a_r6_fetch_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> (state_q == ST_DATA && !req_valid));
  a_r6_token_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && state_q == ST_TOKEN) |=> (card_byte == TOKEN_BYTE && state_q == ST_DATA));
  a_r9_stop_abort: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> (state_q == ST_ARG && stop_q && card_byte == FILL_BYTE));
  a_r11_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |=> ($stable(card_byte) && $stable(state_q)));
  a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |-> (!req_valid && !rd_strobe));
endmodule

// File: tb/sdspi_card_seq_tb.sv
module sdspi_card_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        xfer_valid;
  logic [7:0]  host_byte;
  logic [7:0]  card_byte;
  logic        req_valid;
  logic [5:0]  req_cmd;
  logic [31:0] req_arg;
  logic [2:0]  rsp_len;
  logic [39:0] rsp_bytes;
  logic        rsp_data;
  logic        rd_strobe;
  logic [7:0]  rd_byte;
  logic        rd_last;

  int n_chk;
  int n_bad;
  bit done;

  logic [7:0] blk [16];
  int         blk_n;
  int         rd_pos;

  logic        s_req, s_rd;
  logic [5:0]  s_cmd;
  logic [31:0] s_arg;

  sdspi_card_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_valid (xfer_valid),
    .host_byte  (host_byte),
    .card_byte  (card_byte),
    .req_valid  (req_valid),
    .req_cmd    (req_cmd),
    .req_arg    (req_arg),
    .rsp_len    (rsp_len),
    .rsp_bytes  (rsp_bytes),
    .rsp_data   (rsp_data),
    .rd_strobe  (rd_strobe),
    .rd_byte    (rd_byte),
    .rd_last    (rd_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Back-end model for the read data.
  assign rd_byte = blk[rd_pos[3:0]];
  assign rd_last = (rd_pos == blk_n - 1);
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pos <= 0;
    else if (req_valid) rd_pos <= 0;
    else if (rd_strobe) rd_pos <= rd_pos + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int b = 0; b < 8; b++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] rsp_pat(input int cmd, input int k);
    return 8'((cmd * 4 + k * 41 + 3) & 255);
  endfunction

  task automatic xchg(input logic [7:0] hb, output logic [7:0] cb);
    @(negedge clk);
    host_byte  = hb;
    xfer_valid = 1'b1;
    #1;
    s_req = req_valid;
    s_rd  = rd_strobe;
    s_cmd = req_cmd;
    s_arg = req_arg;
    @(negedge clk);
    xfer_valid = 1'b0;
    host_byte  = 8'h00;
    cb = card_byte;
  endtask

  task automatic setup(input int cmd, input int len, input bit dat, input int nblk, input int seed);
    rsp_len  = 3'(len);
    rsp_data = dat;
    for (int k = 0; k < 5; k++) rsp_bytes[k*8 +: 8] = rsp_pat(cmd, k);
    blk_n = nblk;
    for (int i = 0; i < 16; i++) blk[i] = 8'((seed * 37 + i * 11 + 5) & 255);
  endtask

  // Sends the command byte, the argument bytes and the CRC slot that carries the gap.
  task automatic send_frame(input int cmd, input logic [31:0] arg);
    logic [7:0] cb;
    xchg(8'h40 | 8'(cmd), cb);
    chk("R2 cmd byte reply", cb, 8'hFF);
    chk("R2 no req on cmd byte", s_req, 0);
    for (int a = 0; a < 4; a++) begin
      xchg(arg[31 - a*8 -: 8], cb);
      chk("R2 arg reply", cb, 8'hFF);
      chk("R2 req strobe timing", s_req, (a == 3));
      if (a == 3) begin
        chk("R2 req cmd", s_cmd, cmd);
        chk("R2 req arg", s_arg, arg);
      end
    end
    xchg(8'h95, cb);
    chk("R3 Ncr gap", cb, 8'hFF);
  endtask

  task automatic run_cmd(input int cmd, input logic [31:0] arg, input int len,
                         input bit dat, input int nblk, input int seed);
    logic [7:0]  cb;
    logic [15:0] crc;
    int eff;
    setup(cmd, len, dat, nblk, seed);
    send_frame(cmd, arg);
    eff = (len == 0) ? 1 : (len > 5) ? 5 : len;
    for (int k = 0; k < eff; k++) begin
      xchg(8'hFF, cb);
      chk("R4 R5 response byte", cb, rsp_pat(cmd, k));
      if (k == 0) begin
        repeat (3) @(negedge clk);
        chk("R11 output held", card_byte, rsp_pat(cmd, 0));
        chk("R11 no strobe", {30'd0, req_valid, rd_strobe}, 0);
      end
    end
    if (dat) begin
      xchg(8'hFF, cb);
      chk("R6 Nac gap", cb, 8'hFF);
      xchg(8'hFF, cb);
      chk("R6 start token", cb, 8'hFE);
      crc = 16'h0000;
      for (int i = 0; i < nblk; i++) begin
        xchg(8'hFF, cb);
        chk("R6 data byte", cb, blk[i]);
        chk("R6 fetch strobe", s_rd, 1);
        crc = crc_step(crc, blk[i]);
      end
      xchg(8'hFF, cb);
      chk("R7 R8 crc high", cb, crc[15:8]);
      chk("R7 no fetch in crc", s_rd, 0);
      xchg(8'hFF, cb);
      chk("R7 R8 crc low", cb, crc[7:0]);
    end
    xchg(8'hFF, cb);
    chk("R4 R7 back to idle", cb, 8'hFF);
    chk("R1 null no req", s_req, 0);
  endtask

  initial begin
    logic [7:0] cb;
    logic [15:0] crc;
    n_chk = 0;
    n_bad = 0;
    done  = 0;
    rst_n = 1'b0;
    xfer_valid = 1'b0;
    host_byte  = 8'h00;
    setup(0, 1, 0, 1, 0);
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset card byte", card_byte, 8'hFF);
    chk("R10 reset strobes", {30'd0, req_valid, rd_strobe}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after release", card_byte, 8'hFF);

    // R1: null commands while idle.
    for (int n = 0; n < 3; n++) begin
      xchg(8'hFF, cb);
      chk("R1 null reply", cb, 8'hFF);
      chk("R1 null no req", s_req, 0);
    end

    // Sweep of all length codes, with and without a block.
    for (int len = 0; len < 8; len++) begin
      for (int d = 0; d < 2; d++) begin
        run_cmd(len * 7 + d, 32'h1234_5678 ^ (len * 32'h0101_0101), len, d[0],
                1 + len * 2, len * 2 + d);
      end
    end

    // R8: fixed block "123456789" gives 0x31C3.
    setup(17, 1, 1, 9, 0);
    for (int i = 0; i < 9; i++) blk[i] = 8'h31 + 8'(i);
    send_frame(17, 32'h0000_0200);
    xchg(8'hFF, cb);
    chk("R4 single response", cb, rsp_pat(17, 0));
    xchg(8'hFF, cb);
    xchg(8'hFF, cb);
    chk("R6 token", cb, 8'hFE);
    for (int i = 0; i < 9; i++) xchg(8'hFF, cb);
    xchg(8'hFF, cb);
    chk("R8 known crc high", cb, 8'h31);
    xchg(8'hFF, cb);
    chk("R8 known crc low", cb, 8'hC3);

    // Next block must start again from zero.
    run_cmd(17, 32'h0000_0400, 1, 1, 16, 9);

    // R9: stop during a read.
    setup(18, 1, 1, 12, 4);
    send_frame(18, 32'h0000_1000);
    xchg(8'hFF, cb);
    xchg(8'hFF, cb);
    chk("R6 Nac before stop", cb, 8'hFF);
    xchg(8'hFF, cb);
    chk("R6 token before stop", cb, 8'hFE);
    for (int i = 0; i < 3; i++) begin
      xchg(8'hFF, cb);
      chk("R6 data before stop", cb, blk[i]);
    end
    rsp_len = 3'd2;
    for (int k = 0; k < 5; k++) rsp_bytes[k*8 +: 8] = rsp_pat(12, k);
    rsp_data = 1'b0;
    xchg(8'h4C, cb);
    chk("R9 stop byte reply", cb, 8'hFF);
    chk("R9 stop fetches nothing", s_rd, 0);
    for (int a = 0; a < 4; a++) begin
      xchg(8'h00, cb);
      chk("R9 stop arg reply", cb, 8'hFF);
      if (a == 3) begin
        chk("R9 stop req", s_req, 1);
        chk("R9 stop index 12", s_cmd, 12);
      end
    end
    xchg(8'hFF, cb);
    chk("R9 Ncr after stop", cb, 8'hFF);
    xchg(8'hFF, cb);
    chk("R9 extra delay byte", cb, 8'hFF);
    xchg(8'hFF, cb);
    chk("R9 stop response 0", cb, rsp_pat(12, 0));
    xchg(8'hFF, cb);
    chk("R9 stop response 1", cb, rsp_pat(12, 1));
    xchg(8'hFF, cb);
    chk("R9 idle, no crc", cb, 8'hFF);
    chk("R9 idle no fetch", s_rd, 0);

    // A normal command afterwards has no extra delay.
    run_cmd(9, 32'hDEAD_BEEF, 5, 0, 1, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule